// File: doc/BRIEF.md
# Recursive Second-Order Pixel Smoother

This block smooths a stream of 10-bit pixel intensities along one line at a time. It uses a two-pole recursive filter with a single programmable pole γ. Each output is y(n) = (1−γ)²·x(n) + 2γ·y(n−1) − γ²·y(n−2). Software writes γ as an unsigned fixed-point word with 15 fraction bits. Smoothing on noisy pictures uses γ near 0.5–0.6, and smoothing on cleaner pictures uses γ near 0.37–0.45. The block derives the three tap coefficients from γ in a short pipeline and then streams one pixel per clock. A start-of-line marker on the first pixel of every line empties the recursion history.

For a separable 2D result, a surrounding controller passes the image through the block row by row. It then passes the intermediate result through again column by column. Output values keep `FRAC_OUT` fraction bits above the pixel scale. They are rounded, then saturated to a signed 16-bit word.

A small controller sequences the block through four states:
- `ST_CFG_WAIT`: no coefficients are loaded yet.
- `ST_LATCH`: the squares of γ and of 1−γ are formed.
- `ST_DERIVE`: the rounded coefficients are written.
- `ST_STREAM`: pixels are accepted.

The transitions are:
- `CFG_WAIT→LATCH`, `STREAM→LATCH`, `DERIVE→LATCH` and `LATCH→LATCH`: taken on any γ write.
- `LATCH→DERIVE`: taken unconditionally.
- `DERIVE→STREAM`: taken unconditionally.
- `CFG_WAIT→CFG_WAIT` and `STREAM→STREAM`: taken when there is no write.

Top module: `pix_iir_smooth`

## Requirements
- R1: After reset, and until the first γ write, `in_ready` and `out_valid` stay 0.
- R2: After the clock edge that samples `gamma_wr`=1, `in_ready` is 0 for the next two cycles. It is 1 in the third cycle if no further write occurred.
- R3: A written `gamma_val` with bit 15 set (1.0 or more) is treated as 0x7FFF.
- R4: The coefficients are computed from the clamped γ value g, with s = 2^15:
  - c0 = ((s−g)² + 2^14) >> 15
  - c1 = 2g
  - c2 = (g² + 2^14) >> 15
- R5: For each accepted pixel x, let a = c0·(x·2^FRAC_OUT) + c1·y1 − c2·y2 in signed arithmetic. The output is (a + 2^14) >>> 15 after R6 saturation. The history then shifts: y2←y1 and y1←output.
- R6: A result above 32767 is output as 32767, and a result below −32768 is output as −32768.
- R7: A pixel accepted with `in_sol`=1 uses y1=y2=0.
- R8: `out_valid` is 1 exactly in the cycle after each accepted pixel (`in_valid`&&`in_ready`), and 0 otherwise.
- R9: `in_valid` while `in_ready` is 0 produces no output and leaves the history unchanged.
- R10: In `ST_STREAM` without a γ write, `in_ready` stays 1 on every cycle, whatever `in_valid` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gamma_wr | input | 1 | Write strobe for γ |
| gamma_val | input | 16 | γ, unsigned, 15 fraction bits |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| in_sol | input | 1 | Pixel is the first of a line |
| in_pix | input | 10 | Pixel intensity |
| out_valid | output | 1 | Output sample present |
| out_data | output | 16 | Smoothed value, signed, FRAC_OUT fraction bits |

## Verification
The bound checker watches the following on every cycle:
- the quiet interval before the first γ write;
- the two-cycle drop of `in_ready` after a γ write;
- that `in_ready` holds while streaming;
- the one-to-one, one-cycle link between an accepted pixel and `out_valid`.

The numeric behaviour can only be shown by the bench scenarios, which compare every output against a bench model of the recurrence. This covers the coefficient rounding, the clamp of γ, the clearing of history at line starts, saturation (on a second instance with more fraction bits), and the fact that pixels offered while not ready leave no trace.

// File: rtl/pix_iir_pkg.sv
package pix_iir_pkg;
    typedef enum logic [1:0] {
        ST_CFG_WAIT,
        ST_LATCH,
        ST_DERIVE,
        ST_STREAM
    } smooth_state_e;
endpackage

// File: rtl/pix_iir_ctrl.sv
module pix_iir_ctrl
    import pix_iir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gamma_wr,
    output logic in_ready,
    output logic sq_en,
    output logic cf_en
);
    smooth_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CFG_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (gamma_wr) begin
            state_d = ST_LATCH;
        end else begin
            unique case (state_q)
                ST_CFG_WAIT: state_d = ST_CFG_WAIT;
                ST_LATCH:    state_d = ST_DERIVE;
                ST_DERIVE:   state_d = ST_STREAM;
                ST_STREAM:   state_d = ST_STREAM;
            endcase
        end
    end

    always_comb begin
        in_ready = 1'b0;
        sq_en    = 1'b0;
        cf_en    = 1'b0;
        unique case (state_q)
            ST_CFG_WAIT: ;
            ST_LATCH:    sq_en    = 1'b1;
            ST_DERIVE:   cf_en    = 1'b1;
            ST_STREAM:   in_ready = 1'b1;
        endcase
    end
endmodule

// File: rtl/pix_iir_coef.sv
module pix_iir_coef #(
    parameter int GF = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          sq_en,
    input  logic          cf_en,
    input  logic [GF:0]   gamma_val,
    output logic [GF+1:0] c0,
    output logic [GF+1:0] c1,
    output logic [GF+1:0] c2
);
    localparam int SQ_W = 2 * GF + 2;
    localparam logic [SQ_W-1:0] RND  = SQ_W'(1) << (GF - 1);
    localparam logic [GF:0]     UNIT = (GF + 1)'(1) << GF;

    logic [GF-1:0]   g_q;
    logic [GF:0]     om;
    logic [SQ_W-1:0] sq_om_q, sq_g_q;

    // clamp: anything at or above 1.0 becomes the largest fraction
    logic [GF-1:0] g_clamped;
    assign g_clamped = gamma_val[GF] ? {GF{1'b1}} : gamma_val[GF-1:0];
    assign om        = UNIT - {1'b0, g_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q     <= '0;
            sq_om_q <= '0;
            sq_g_q  <= '0;
            c0      <= '0;
            c1      <= '0;
            c2      <= '0;
        end else begin
            if (load) g_q <= g_clamped;
            if (sq_en) begin
                sq_om_q <= SQ_W'(om) * SQ_W'(om);
                sq_g_q  <= SQ_W'(g_q) * SQ_W'(g_q);
            end
            if (cf_en) begin
                c0 <= (GF + 2)'((sq_om_q + RND) >> GF);
                c1 <= {1'b0, g_q, 1'b0};
                c2 <= (GF + 2)'((sq_g_q + RND) >> GF);
            end
        end
    end
endmodule

// File: rtl/pix_iir_core.sv
module pix_iir_core #(
    parameter int PIX_W    = 10,
    parameter int GF       = 15,
    parameter int OUT_W    = 16,
    parameter int FRAC_OUT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic                    sol,
    input  logic [PIX_W-1:0]        pix,
    input  logic [GF+1:0]           c0,
    input  logic [GF+1:0]           c1,
    input  logic [GF+1:0]           c2,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int COEF_W = GF + 2;
    localparam int XW     = PIX_W + FRAC_OUT;
    localparam int WIDE   = (XW > OUT_W) ? XW : OUT_W;
    localparam int ACC_W  = COEF_W + WIDE + 3;
    localparam logic signed [ACC_W-1:0] RND     = ACC_W'(1) << (GF - 1);
    localparam logic signed [ACC_W-1:0] SAT_MAX = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_MIN = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [OUT_W-1:0] y1_q, y2_q, y1_h, y2_h, y_new;
    logic signed [ACC_W-1:0] coef_x [3];
    logic signed [ACC_W-1:0] opnd_x [3];
    logic signed [ACC_W-1:0] prod   [3];
    logic signed [ACC_W-1:0] sum, shr;

    // start of line: recursion sees an empty history
    assign y1_h = sol ? '0 : y1_q;
    assign y2_h = sol ? '0 : y2_q;

    always_comb begin
        coef_x[0] = $signed({{(ACC_W-COEF_W){1'b0}}, c0});
        coef_x[1] = $signed({{(ACC_W-COEF_W){1'b0}}, c1});
        coef_x[2] = $signed({{(ACC_W-COEF_W){1'b0}}, c2});
        opnd_x[0] = $signed({{(ACC_W-XW){1'b0}}, pix, {FRAC_OUT{1'b0}}});
        opnd_x[1] = $signed({{(ACC_W-OUT_W){y1_h[OUT_W-1]}}, y1_h});
        opnd_x[2] = $signed({{(ACC_W-OUT_W){y2_h[OUT_W-1]}}, y2_h});
    end

    for (genvar k = 0; k < 3; k++) begin : g_tap
        assign prod[k] = coef_x[k] * opnd_x[k];
    end

    always_comb begin
        sum = prod[0] + prod[1] - prod[2] + RND;
        shr = sum >>> GF;
        if (shr > SAT_MAX)      y_new = SAT_MAX[OUT_W-1:0];
        else if (shr < SAT_MIN) y_new = SAT_MIN[OUT_W-1:0];
        else                    y_new = shr[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y1_q      <= '0;
            y2_q      <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= acc_en;
            if (acc_en) begin
                y1_q     <= y_new;
                y2_q     <= y1_h;
                out_data <= y_new;
            end
        end
    end
endmodule

// File: rtl/pix_iir_smooth.sv
module pix_iir_smooth #(
    parameter int PIX_W    = 10,
    parameter int GF       = 15,
    parameter int OUT_W    = 16,
    parameter int FRAC_OUT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    gamma_wr,
    input  logic [GF:0]             gamma_val,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_sol,
    input  logic [PIX_W-1:0]        in_pix,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    logic          sq_en, cf_en, acc_en;
    logic [GF+1:0] c0, c1, c2;

    assign acc_en = in_valid && in_ready;

    pix_iir_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .gamma_wr (gamma_wr),
        .in_ready (in_ready),
        .sq_en    (sq_en),
        .cf_en    (cf_en)
    );

    pix_iir_coef #(.GF(GF)) u_coef (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (gamma_wr),
        .sq_en     (sq_en),
        .cf_en     (cf_en),
        .gamma_val (gamma_val),
        .c0        (c0),
        .c1        (c1),
        .c2        (c2)
    );

    pix_iir_core #(
        .PIX_W    (PIX_W),
        .GF       (GF),
        .OUT_W    (OUT_W),
        .FRAC_OUT (FRAC_OUT)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .sol       (in_sol),
        .pix       (in_pix),
        .c0        (c0),
        .c1        (c1),
        .c2        (c2),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/pix_iir_chk.sv
module pix_iir_chk (
    input logic clk,
    input logic rst_n,
    input logic gamma_wr,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid
);
    logic cfg_seen;

    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_seen <= 1'b0;
        else if (gamma_wr) cfg_seen <= 1'b1;
    end

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_seen |-> (!in_ready && !out_valid));

    p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gamma_wr |=> !in_ready ##1 !in_ready);

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_no_spur_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !gamma_wr) |=> in_ready);
endmodule

bind pix_iir_smooth pix_iir_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gamma_wr  (gamma_wr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid)
);

// File: tb/pix_iir_smooth_tb.sv
module pix_iir_smooth_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gamma_wr = 1'b0;
    logic [15:0] gamma_val = '0;
    logic in_valid = 1'b0, in_sol = 1'b0;
    logic [9:0] in_pix = '0;
    logic in_ready, in_ready_s, out_valid, out_valid_s;
    logic signed [15:0] out_data, out_data_s;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pix_iir_smooth #(.FRAC_OUT(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .gamma_wr(gamma_wr), .gamma_val(gamma_val),
        .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol), .in_pix(in_pix),
        .out_valid(out_valid), .out_data(out_data));

    pix_iir_smooth #(.FRAC_OUT(6)) u_dut_sat (
        .clk(clk), .rst_n(rst_n), .gamma_wr(gamma_wr), .gamma_val(gamma_val),
        .in_valid(in_valid), .in_ready(in_ready_s), .in_sol(in_sol), .in_pix(in_pix),
        .out_valid(out_valid_s), .out_data(out_data_s));

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit rdy_seen = 0;
    bit exp_v = 0;
    longint exp_d = 0, exp_ds = 0;
    longint last_out = 0, last_out_s = 0;
    longint m_c0 = 0, m_c1 = 0, m_c2 = 0;
    longint my1 [2], my2 [2];
    int yf [2] = '{4, 6};

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // R3/R4 model of the coefficient derivation
    function automatic void model_gamma(input int gv);
        longint g, om;
        g    = (gv >= 32768) ? 32767 : gv;
        om   = 32768 - g;
        m_c0 = (om * om + 16384) >> 15;
        m_c1 = 2 * g;
        m_c2 = (g * g + 16384) >> 15;
    endfunction

    // R5/R6/R7 model of one recursion step
    function automatic longint model_step(input int idx, input int x, input bit sol);
        longint y1, y2, acc, r;
        y1  = sol ? 0 : my1[idx];
        y2  = sol ? 0 : my2[idx];
        acc = m_c0 * (longint'(x) <<< yf[idx]) + m_c1 * y1 - m_c2 * y2;
        r   = (acc + 16384) >>> 15;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        my2[idx] = y1;
        my1[idx] = r;
        return r;
    endfunction

    task automatic cyc(input bit v, input bit s, input int px, input bit gw, input int gv);
        @(negedge clk);
        #1;
        rdy_seen  = in_ready;
        in_valid  = v;
        in_sol    = s;
        in_pix    = px[9:0];
        gamma_wr  = gw;
        gamma_val = gv[15:0];
        exp_v     = v && rdy_seen;   // R9: not-ready offers are dropped
        if (exp_v) begin
            exp_d  = model_step(0, px, s);
            exp_ds = model_step(1, px, s);
        end
        if (gw) model_gamma(gv);
    endtask

    // monitor: runs at negedge, before the driver's #1
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(out_valid == exp_v, "R8 out_valid", longint'(out_valid), longint'(exp_v));
            if (exp_v) begin
                chk(out_data == exp_d, "R5 out_data", out_data, exp_d);
                chk(out_data_s == exp_ds, "R6 out_data sat inst", out_data_s, exp_ds);
            end
            last_out   = out_data;
            last_out_s = out_data_s;
        end
        exp_v = 0;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lcnt;
        void'($urandom(32'd4177));
        for (int i = 0; i < 2; i++) begin my1[i] = 0; my2[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, no configuration yet
        cyc(0, 0, 0, 0, 0);
        chk(rdy_seen == 0, "R1 in_ready", longint'(rdy_seen), 0);
        chk(out_valid == 0, "R1 out_valid", longint'(out_valid), 0);
        // R9: offers while not ready
        for (int i = 0; i < 3; i++) cyc(1, 1, 500 + i, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk(out_valid == 0, "R9 no output while not ready", longint'(out_valid), 0);

        // R2: two-cycle configuration gap
        cyc(0, 0, 0, 1, 16384);
        cyc(0, 0, 0, 0, 0);
        chk(rdy_seen == 0, "R2 gap cycle 1", longint'(rdy_seen), 0);
        cyc(0, 0, 0, 0, 0);
        chk(rdy_seen == 0, "R2 gap cycle 2", longint'(rdy_seen), 0);
        cyc(0, 0, 0, 0, 0);
        chk(rdy_seen == 1, "R2 ready after gap", longint'(rdy_seen), 1);
        // R10: ready holds while idle
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 0, 0, 0);
            chk(rdy_seen == 1, "R10 ready holds", longint'(rdy_seen), 1);
        end

        // R7 and R4 (gamma 0.5: c0=8192 c1=32768 c2=8192): build history, then restart line
        cyc(1, 1, 1000, 0, 0);
        for (int i = 0; i < 5; i++) cyc(1, 0, 1000, 0, 0);
        cyc(1, 1, 100, 0, 0);
        cyc(1, 0, 100, 0, 0);
        chk(last_out == 400, "R7 first pixel after line start", last_out, 400);
        cyc(1, 0, 100, 0, 0);
        chk(last_out == 800, "R4 second pixel of line", last_out, 800);
        cyc(0, 0, 0, 0, 0);
        chk(last_out == 1100, "R7 cleared y2 history", last_out, 1100);

        // R6: gamma 0 passes x scaled; 1023*64 saturates on the 6-bit instance
        cyc(0, 0, 0, 1, 0);
        repeat (3) cyc(0, 0, 0, 0, 0);
        cyc(1, 1, 1023, 0, 0);
        cyc(1, 0, 1023, 0, 0);
        chk(last_out_s == 32767, "R6 saturation", last_out_s, 32767);
        chk(last_out == 16368, "R5 unit gain gamma 0", last_out, 16368);

        // R3: gamma >= 1.0 clamps to 0x7FFF, whose c0 rounds to 0
        cyc(0, 0, 0, 1, 16'hFFFF);
        repeat (3) cyc(0, 0, 0, 0, 0);
        cyc(1, 1, 1023, 0, 0);
        cyc(1, 0, 1023, 0, 0);
        chk(last_out == 0, "R3 clamp first", last_out, 0);
        cyc(0, 0, 0, 0, 0);
        chk(last_out == 0, "R3 clamp second", last_out, 0);

        // random streams over several pole settings
        lcnt = 0;
        foreach (yf[i]) ;
        for (int gi = 0; gi < 5; gi++) begin
            int gv;
            case (gi)
                0: gv = 19875;
                1: gv = 12055;
                2: gv = 23000;
                3: gv = 14500;
                default: gv = int'($urandom_range(32767, 0));
            endcase
            cyc(0, 0, 0, 1, gv);
            // R9: random offers during the gap are dropped
            cyc(1, 0, int'($urandom_range(1023, 0)), 0, 0);
            cyc(1, 0, int'($urandom_range(1023, 0)), 0, 0);
            lcnt = 0;
            for (int i = 0; i < 400; i++) begin
                bit v;
                int px;
                v  = ($urandom_range(99, 0) < 75);
                px = (i % 50 < 5) ? 1023 : int'($urandom_range(1023, 0));
                cyc(v, lcnt == 0, px, 0, 0);
                if (v && rdy_seen) lcnt = (lcnt + 1) % 24;
            end
        end
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule